// File: doc/BRIEF.md
# Debug Halt Clock Gate Controller

This block decides when the core timer logic of a peripheral stops and restarts for debugging. When a debugger asks for a halt, the core clock is gated off. Every time base and counter in the core domain then holds its value. The gating cell itself lives elsewhere; this block drives its enable.

A halt request counts only when the debug-enable bit is set and the module-disable bit is clear. Entry into halt is held back until the slave bus has been idle for a configurable number of consecutive cycles. This keeps a read or write in progress from being cut off. Leaving halt needs no bus condition. The RAM-domain enable and the bus logic keep running throughout, so every register and RAM word stays reachable while the core is frozen. All inputs are assumed synchronous to `clk`.

Top module: `dbg_halt_gate`

## Requirements
- R1: After a synchronous active-low reset, `core_clk_en` is 1, `halted` is 0 and `ram_clk_en` is 1.
- R2: A halt request is qualified only when `halt_req` and `dbg_en` are both 1 and `mod_dis` is 0. Without a qualified request, a running core never halts.
- R3: With the default `IDLE_CYCLES` of 2, the core halts after `IDLE_CYCLES` consecutive cycles in which the request is qualified and `bus_busy` is 0. `halted` rises, and `core_clk_en` falls, on the clock edge that closes the last of those cycles.
- R4: A cycle with `bus_busy` = 1, or with no qualified request, restarts the idle count. No halt is entered on that edge, and a full window of idle cycles is needed afterwards.
- R5: While `mod_dis` is 1, a debug request is ignored and the core keeps running. Counting starts only in the first cycle after `mod_dis` is cleared.
- R6: A halted core resumes on the first clock edge at which the request is no longer qualified (`halt_req` low, `dbg_en` low or `mod_dis` high), whatever the state of `bus_busy`.
- R7: `halted` is always the inverse of `core_clk_en`, and both change on the same edge.
- R8: `ram_clk_en` is 1 in every cycle, halted or not.
- R9: While halted with the request still qualified, `bus_busy` activity does not change the halt state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_req | input | 1 | Halt request from the debug interface |
| dbg_en | input | 1 | Debug-enable bit, set through the debug interface |
| mod_dis | input | 1 | Module-disable bit; masks the request |
| bus_busy | input | 1 | Slave bus read or write in progress |
| core_clk_en | output | 1 | Enable for the core-domain clock gate |
| ram_clk_en | output | 1 | Enable for the RAM-domain clock gate, always on |
| halted | output | 1 | Core is in debug halt |

## Verification
The bench sweeps every sequence of three input vectors (16 values each) from both the running and the halted state. It compares each cycle against an arithmetic model of the idle window.

- A design that sampled only one idle cycle would halt one edge early.
- A design that did not clear the count on a busy cycle would halt in the middle of an access.
- A design that let `mod_dis` pass would halt while disabled.
- A design that gated exit on bus idle would hold the core frozen after the request is withdrawn.

Targeted cases cover a busy cycle landing in the last slot of the window and a disable bit cleared in the middle of a request.

// File: rtl/dhg_pkg.sv
// Package: shared state type for the debug halt clock gate controller.
// Assumes: nothing beyond IEEE 1800-2017.
package dhg_pkg;

    // Core halt state: running, collecting idle cycles, halted.
    typedef enum logic [1:0] {
        DHG_RUN  = 2'd0,
        DHG_WAIT = 2'd1,
        DHG_HALT = 2'd2
    } dhg_state_e;

endpackage

// File: rtl/dhg_req_qual.sv
// Module: dhg_req_qual
// Combines the raw debug halt request with the enable and disable bits.
// Assumes: all inputs synchronous to the consumer's clock; no state here.
module dhg_req_qual (
    input  logic halt_req,
    input  logic dbg_en,
    input  logic mod_dis,
    output logic req_ok
);

    // Qualify the request: needs enable, is masked by module-disable.
    always_comb begin
        req_ok = halt_req & dbg_en & ~mod_dis;
    end

endmodule

// File: rtl/dhg_idle_win.sv
// Module: dhg_idle_win
// Counts consecutive cycles in which halt entry is allowed (request
// qualified, bus idle, not yet halted). Signals when the window closes.
// Assumes: IDLE_CYCLES >= 1; count_en is registered-input clean.
module dhg_idle_win #(
    parameter int IDLE_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en,
    output logic window_done
);

    localparam int CW = (IDLE_CYCLES > 1) ? $clog2(IDLE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(IDLE_CYCLES - 1);

    logic [CW-1:0] idle_cnt;

    // Window closes in the cycle that completes the required idle run.
    always_comb begin
        window_done = count_en && (idle_cnt == LAST);
    end

    // Run counter: clears on any non-idle cycle or when the window closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
        end else if (!count_en || window_done) begin
            idle_cnt <= '0;
        end else begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    // R4: a broken run leaves the counter at zero for the next cycle.
    a_r4_run_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !count_en |=> (idle_cnt == '0));

    // R3: counter never passes the last slot of the window.
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cnt <= LAST);

endmodule

// File: rtl/dhg_halt_fsm.sv
// Module: dhg_halt_fsm
// Holds the halt state and drives the registered core enable and halted
// flag. Entry comes from the idle window; exit is immediate once the
// qualified request drops.
// Assumes: window_done is only asserted while not halted.
module dhg_halt_fsm
    import dhg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_ok,
    input  logic window_done,
    output logic in_halt,
    output logic core_en_q,
    output logic halted_q
);

    dhg_state_e state_q;
    dhg_state_e state_d;

    // Next-state decision for entry and exit.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DHG_RUN, DHG_WAIT: begin
                if (window_done)  state_d = DHG_HALT;
                else if (req_ok)  state_d = DHG_WAIT;
                else              state_d = DHG_RUN;
            end
            DHG_HALT: begin
                if (!req_ok)      state_d = DHG_RUN;
            end
            default:              state_d = DHG_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DHG_RUN;
        else        state_q <= state_d;
    end

    // Output flops: enable and flag updated on the same edge as the state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_en_q <= 1'b1;
            halted_q  <= 1'b0;
        end else begin
            core_en_q <= (state_d != DHG_HALT);
            halted_q  <= (state_d == DHG_HALT);
        end
    end

    // Expose the halt state to gate the idle counter.
    always_comb begin
        in_halt = (state_q == DHG_HALT);
    end

    // R7: the two output flops never disagree.
    a_r7_flag_matches_en: assert property (@(posedge clk) disable iff (!rst_n)
        core_en_q != halted_q);

    // R6: a halted core with no qualified request resumes next edge.
    a_r6_prompt_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_q && !req_ok) |=> core_en_q);

    // R2: without a qualified request a running core stays running.
    a_r2_no_req_no_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted_q && !req_ok) |=> !halted_q);

endmodule

// File: rtl/dbg_halt_gate.sv
// Module: dbg_halt_gate (top)
// Debug halt clock gate controller. Gates the core clock when a qualified
// debug halt request has coincided with an idle slave bus for IDLE_CYCLES
// consecutive cycles; keeps the RAM domain clocked at all times.
// Assumes: inputs synchronous to clk; the gating cell is external.
module dbg_halt_gate #(
    parameter int IDLE_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_req,
    input  logic dbg_en,
    input  logic mod_dis,
    input  logic bus_busy,
    output logic core_clk_en,
    output logic ram_clk_en,
    output logic halted
);

    logic req_ok;
    logic in_halt;
    logic count_en;
    logic window_done;

    dhg_req_qual u_qual (
        .halt_req (halt_req),
        .dbg_en   (dbg_en),
        .mod_dis  (mod_dis),
        .req_ok   (req_ok)
    );

    // Idle cycles count only while running with a qualified request.
    always_comb begin
        count_en = req_ok & ~bus_busy & ~in_halt;
    end

    dhg_idle_win #(
        .IDLE_CYCLES (IDLE_CYCLES)
    ) u_win (
        .clk         (clk),
        .rst_n       (rst_n),
        .count_en    (count_en),
        .window_done (window_done)
    );

    dhg_halt_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_ok      (req_ok),
        .window_done (window_done),
        .in_halt     (in_halt),
        .core_en_q   (core_clk_en),
        .halted_q    (halted)
    );

    // RAM domain is never stopped by debug halt.
    always_comb begin
        ram_clk_en = 1'b1;
    end

    // R3: halt is only entered after a cycle with an idle bus.
    a_r3_entry_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> $past(!bus_busy));

    // R5: module-disable keeps a running core running.
    a_r5_disable_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_dis && !halted) |=> !halted);

    // R9: bus activity does not disturb a held halt.
    a_r9_busy_while_halted: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && halt_req && dbg_en && !mod_dis && bus_busy) |=> halted);

endmodule

// File: tb/dbg_halt_gate_test.sv
`timescale 1ns/1ps
module dbg_halt_gate_test;

    localparam int IDLE = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_req = 1'b0, dbg_en = 1'b0, mod_dis = 1'b0, bus_busy = 1'b0;
    logic core_clk_en, ram_clk_en, halted;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // model state
    bit m_halt = 1'b0;
    int m_cnt = 0;

    always #2.5 clk = ~clk;

    dbg_halt_gate #(.IDLE_CYCLES(IDLE)) uut (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .dbg_en(dbg_en),
        .mod_dis(mod_dis), .bus_busy(bus_busy), .core_clk_en(core_clk_en),
        .ram_clk_en(ram_clk_en), .halted(halted)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic apply(input logic [3:0] v);
        {halt_req, dbg_en, mod_dis, bus_busy} = v;
    endtask

    // Pick the requirement that governs this cycle's expected outcome.
    function automatic string tag_of(input bit was_halt, input logic [3:0] v);
        bit q = v[3] & v[2] & ~v[1];
        if (was_halt) return q ? (v[0] ? "R9" : "R6") : "R6";
        if (v[1] && v[3] && v[2]) return "R5";
        if (!q) return "R2";
        if (v[0]) return "R4";
        return "R3";
    endfunction

    // One clock: update model from driven inputs, then compare outputs.
    task automatic step();
        logic [3:0] v = {halt_req, dbg_en, mod_dis, bus_busy};
        bit q = halt_req & dbg_en & ~mod_dis;
        string t = tag_of(m_halt, v);
        @(posedge clk);
        #1;
        if (m_halt) begin
            if (!q) begin m_halt = 0; m_cnt = 0; end
        end else if (q && !bus_busy) begin
            if (m_cnt == IDLE - 1) begin m_halt = 1; m_cnt = 0; end
            else m_cnt++;
        end else begin
            m_cnt = 0;
        end
        check(t, halted, m_halt);
        check("R7", core_clk_en, ~halted);
        check("R8", ram_clk_en, 1'b1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        apply(4'b0000);
        @(posedge clk); @(posedge clk);
        #1;
        rst_n = 1'b1;
        m_halt = 0; m_cnt = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        check("R1", core_clk_en, 1'b1);
        check("R1", halted, 1'b0);
        check("R1", ram_clk_en, 1'b1);

        // R3: exact entry edge, two idle cycles
        apply(4'b1100); step();
        check("R3", halted, 1'b0);
        step();
        check("R3", halted, 1'b1);
        check("R3", core_clk_en, 1'b0);

        // R9: busy while halted keeps halt
        apply(4'b1101); step(); step();
        check("R9", halted, 1'b1);

        // R6: exit on request drop with bus busy
        apply(4'b0101); step();
        check("R6", halted, 1'b0);

        // R4: busy in last slot restarts the window
        do_reset();
        apply(4'b1100); step();
        apply(4'b1101); step();
        check("R4", halted, 1'b0);
        apply(4'b1100); step();
        check("R4", halted, 1'b0);
        step();
        check("R4", halted, 1'b1);

        // R5: disable masks, counting resumes after clear
        do_reset();
        apply(4'b1110); step(); step(); step();
        check("R5", halted, 1'b0);
        apply(4'b1100); step();
        check("R5", halted, 1'b0);
        step();
        check("R5", halted, 1'b1);

        // R6: disable set while halted resumes the core
        apply(4'b1110); step();
        check("R6", core_clk_en, 1'b1);

        // Sweep: every 3-vector sequence from running and halted starts
        for (int pre = 0; pre < 2; pre++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    for (int c = 0; c < 16; c++) begin
                        do_reset();
                        if (pre == 1) begin
                            apply(4'b1100);
                            for (int k = 0; k < IDLE; k++) step();
                        end
                        apply(4'(a)); step();
                        apply(4'(b)); step();
                        apply(4'(c)); step();
                    end
                end
            end
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule